// File: doc/BRIEF.md
# Serial Frame Transmitter with Parity Insertion

This block sends one data word at a time on a single serial output line. A host presents a word together with a format select and parity controls, and pulses a write strobe. While the block is idle, that write is taken: the line drops to a start bit, carries the data bits least significant bit first, and ends on a stop bit. A baud tick input acts as the shift clock. Each tick advances the line by exactly one bit.

Three word lengths are supported: 7, 8 and 9 bits. In the 7-bit and 8-bit formats a generated parity bit can take the position just above the data, which is bit position 7 or 8. The host chooses even or odd parity. The format, the parity controls and the data are all captured at the moment the write is taken. A single-cycle interrupt pulse marks the point where the last data or parity bit has been sent and the stop bit begins. This tells the host that the word has left the buffer. Busy stays high until the stop bit has completed.

Top module: `uart_tx_par`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next cycle shows `txd` = 1, `busy` = 0 and `tx_irq` = 0. This holds even when a frame was in progress.
- R2: While `busy` is 0, `txd` is 1. A cycle with `wr_en` = 1 and `busy` = 0 starts a frame: in the next cycle `busy` = 1 and `txd` = 0 (the start bit).
- R3: Each tick while busy moves `txd` to the next frame bit, with data sent least significant bit first. Between ticks `txd` does not change.
- R4: Encoding of `fmt`: 2'b00 sends 7 data bits, `wr_data[6:0]`. 2'b01 sends 8 data bits, `wr_data[7:0]`. 2'b10 and 2'b11 send 9 data bits, `wr_data[8:0]`.
- R5: With `par_en` = 1 in the 7-bit or 8-bit format, one parity bit follows the last data bit. It sits in bit position 7 or 8 of the frame payload.
- R6: With `par_odd` = 0, the parity bit is the XOR of the sent data bits, so the total count of ones is even. With `par_odd` = 1, it is the inverse of that XOR.
- R7: In the 9-bit format `par_en` has no effect, and no parity bit is sent.
- R8: Format, parity enable, parity sense and data are captured when a write is taken. Changes to them during a frame do not alter that frame.
- R9: The tick that ends the last data or parity bit raises `tx_irq` for exactly one cycle. That cycle is the first cycle in which `txd` shows the stop bit (1).
- R10: The stop bit is 1 and lasts until the next tick. On that tick `busy` falls and `txd` stays 1.
- R11: A write while `busy` is 1 is ignored. This includes a write in the cycle of the tick that completes the stop bit.
- R12: Bits of `wr_data` above the selected data width are never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for a new word |
| wr_data | input | 9 | Word to send |
| fmt | input | 2 | Word format: 00 = 7 bit, 01 = 8 bit, 1x = 9 bit |
| par_en | input | 1 | Insert a parity bit (7-bit and 8-bit formats only) |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| tick | input | 1 | Baud shift tick, one clock wide |
| txd | output | 1 | Serial output line, idles at 1 |
| busy | output | 1 | A frame is in progress |
| tx_irq | output | 1 | One-cycle pulse as the stop bit begins |

## Verification
A new write and the tick that ends the stop bit can land in the same cycle. The frame is completing, busy is still high, and so the write must be dropped. The bench provokes this by raising the write strobe, with fresh data and changed controls, on the final tick of frames. It judges the result by seeing `busy` low and `txd` high in that cycle and in the next one. A second collision is a control change on the tick that enters the stop bit, where the interrupt fires. The bench randomizes the write and parity inputs on every tick and checks each bit and the pulse against the frame captured at the write.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int unsigned SHORT_W = 7;
  localparam int unsigned MID_W   = 8;
  localparam int unsigned LONG_W  = 9;
  localparam int unsigned WORD_W  = LONG_W;

  typedef enum logic [1:0] {
    FMT_SHORT = 2'b00,
    FMT_MID   = 2'b01,
    FMT_LONG  = 2'b10,
    FMT_LONGX = 2'b11
  } fmt_e;

  // number of data bits sent for a format
  function automatic int unsigned data_bits(fmt_e f);
    case (f)
      FMT_SHORT: return SHORT_W;
      FMT_MID:   return MID_W;
      default:   return LONG_W;
    endcase
  endfunction

  // parity may only be inserted below the widest format
  function automatic logic parity_allowed(fmt_e f);
    return (f == FMT_SHORT) || (f == FMT_MID);
  endfunction

  // parity over the lowest n bits, inverted for odd sense
  function automatic logic parity_calc(logic [WORD_W-1:0] d, int unsigned n, logic odd);
    logic p;
    p = odd;
    for (int unsigned i = 0; i < WORD_W; i++) begin
      if (i < n) p = p ^ d[i];
    end
    return p;
  endfunction

endpackage

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int unsigned WORD_W  = uart_tx_pkg::WORD_W,
  parameter int unsigned FRAME_W = WORD_W + 2,
  parameter int unsigned CNT_W   = $clog2(WORD_W + 3)
) (
  input  logic [WORD_W-1:0]  word,
  input  fmt_e               fmt,
  input  logic               par_en,
  input  logic               par_odd,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   ticks_to_stop
);

  int unsigned n_bits;
  logic        with_par;

  always_comb begin
    n_bits   = data_bits(fmt);
    with_par = par_en && parity_allowed(fmt);
    frame    = '1;
    frame[0] = 1'b0;  // start bit
    for (int unsigned i = 0; i < WORD_W; i++) begin
      if (i < n_bits) frame[i+1] = word[i];
    end
    if (with_par) frame[n_bits+1] = parity_calc(word, n_bits, par_odd);
    ticks_to_stop = CNT_W'(n_bits + (with_par ? 32'd1 : 32'd0) + 32'd1);
  end

  // R5 R7: payload plus start is always between 8 and 10 ticks before stop
  always_comb begin
    assert_len_range_R5 : assert (ticks_to_stop >= CNT_W'(SHORT_W + 1) &&
                                  ticks_to_stop <= CNT_W'(LONG_W + 1));
  end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int unsigned FRAME_W = 11,
  parameter int unsigned CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_frame,
  input  logic [CNT_W-1:0]   load_cnt,
  input  logic               tick,
  output logic               txd,
  output logic               busy,
  output logic               enter_stop,
  output logic               frame_done
);

  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   cnt;

  assign enter_stop = busy && tick && (cnt == CNT_W'(1));
  assign frame_done = busy && tick && (cnt == '0);
  assign txd        = sr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr   <= '1;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load && !busy) begin
      sr   <= load_frame;
      cnt  <= load_cnt;
      busy <= 1'b1;
    end else if (busy && tick) begin
      sr <= {1'b1, sr[FRAME_W-1:1]};
      if (cnt != '0) cnt <= cnt - CNT_W'(1);
      else busy <= 1'b0;
    end
  end

  assert_hold_between_ticks_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> ($stable(txd) && busy));

  assert_stop_high_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    enter_stop |=> (txd && busy));

  assert_done_idle_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (!busy && txd));

endmodule

// File: rtl/uart_tx_par.sv
module uart_tx_par
  import uart_tx_pkg::*;
#(
  parameter int unsigned WORD_W = uart_tx_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [1:0]        fmt,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              tick,
  output logic              txd,
  output logic              busy,
  output logic              tx_irq
);

  localparam int unsigned FRAME_W = WORD_W + 2;
  localparam int unsigned CNT_W   = $clog2(WORD_W + 3);

  logic [FRAME_W-1:0] next_frame;
  logic [CNT_W-1:0]   next_cnt;
  logic               load_accept;
  logic               enter_stop;
  logic               frame_done;

  assign load_accept = wr_en && !busy;

  uart_tx_framer #(
    .WORD_W (WORD_W),
    .FRAME_W(FRAME_W),
    .CNT_W  (CNT_W)
  ) framer_i (
    .word         (wr_data),
    .fmt          (fmt_e'(fmt)),
    .par_en       (par_en),
    .par_odd      (par_odd),
    .frame        (next_frame),
    .ticks_to_stop(next_cnt)
  );

  uart_tx_shifter #(
    .FRAME_W(FRAME_W),
    .CNT_W  (CNT_W)
  ) shifter_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_accept),
    .load_frame(next_frame),
    .load_cnt  (next_cnt),
    .tick      (tick),
    .txd       (txd),
    .busy      (busy),
    .enter_stop(enter_stop),
    .frame_done(frame_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) tx_irq <= 1'b0;
    else        tx_irq <= enter_stop;
  end

  assert_reset_idle_R1 : assert property (@(posedge clk)
    !rst_n |=> (txd && !busy && !tx_irq));

  assert_idle_high_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  assert_load_start_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    load_accept |=> (busy && !txd));

  assert_irq_single_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);

  assert_irq_at_stop_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (txd && busy));

  assert_busy_write_ignored_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !tick) |=> $stable(txd));

endmodule

// File: tb/uart_tx_par_tb_top.sv
module uart_tx_par_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic [1:0] fmt = '0;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       tick = 1'b0;
  logic       txd, busy, tx_irq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  uart_tx_par dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .fmt(fmt),
    .par_en(par_en), .par_odd(par_odd), .tick(tick),
    .txd(txd), .busy(busy), .tx_irq(tx_irq)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // bench view of the frame: number of payload bits and their values
  function automatic int exp_len(logic [1:0] f, logic pe);
    int n;
    n = (f == 2'b00) ? 7 : (f == 2'b01) ? 8 : 9;
    if (pe && n < 9) n = n + 1;
    return n;
  endfunction

  function automatic logic exp_bit(logic [1:0] f, logic pe, logic odd, logic [8:0] d, int k);
    int n, ones;
    n = (f == 2'b00) ? 7 : (f == 2'b01) ? 8 : 9;
    if (k < n) return d[k];
    ones = 0;
    for (int i = 0; i < n; i++) ones += int'(d[i]);
    return odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
  endfunction

  task automatic noise(input bit on);
    if (on) begin
      wr_en   = 1'($urandom);
      wr_data = 9'($urandom);
      fmt     = 2'($urandom);
      par_en  = 1'($urandom);
      par_odd = 1'($urandom);
    end else wr_en = 1'b0;
  endtask

  task automatic send(input logic [1:0] f, input logic pe, input logic odd,
                      input logic [8:0] d, input bit nz);
    int  len;
    logic cur;
    len = exp_len(f, pe);
    @(negedge clk);
    fmt = f; par_en = pe; par_odd = odd; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk(busy == 1'b1, "R2 busy after write", int'(busy), 1);
    chk(txd == 1'b0, "R2 start bit", int'(txd), 0);
    cur = 1'b0;
    for (int t = 1; t <= len + 1; t++) begin
      int gap;
      gap = 1 + int'($urandom % 3);
      for (int g = 0; g < gap; g++) begin
        noise(nz);
        @(negedge clk);
        chk(txd == cur, "R3 R8 R11 bit held between ticks", int'(txd), int'(cur));
        chk(tx_irq == 1'b0, "R9 no pulse mid frame", int'(tx_irq), 0);
      end
      noise(nz);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      cur = (t <= len) ? exp_bit(f, pe, odd, d, t - 1) : 1'b1;
      if (t <= len)
        chk(txd == cur, "R3 R4 R5 R6 R7 R12 payload bit", int'(txd), int'(cur));
      else begin
        chk(txd == 1'b1, "R10 stop bit high", int'(txd), 1);
        chk(tx_irq == 1'b1, "R9 pulse as stop begins", int'(tx_irq), 1);
        chk(busy == 1'b1, "R10 busy during stop", int'(busy), 1);
      end
    end
    // stop bit lasts until next tick; write collides with final tick
    @(negedge clk);
    chk(tx_irq == 1'b0, "R9 pulse single cycle", int'(tx_irq), 0);
    chk(txd == 1'b1, "R10 stop held", int'(txd), 1);
    wr_en = 1'b1; wr_data = 9'h000; fmt = 2'($urandom); tick = 1'b1;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk(busy == 1'b0, "R10 busy drops on stop tick", int'(busy), 0);
    chk(txd == 1'b1, "R11 write on final tick ignored", int'(txd), 1);
    @(negedge clk);
    chk(busy == 1'b0, "R11 no frame started by final-tick write", int'(busy), 0);
    chk(txd == 1'b1, "R2 idle high", int'(txd), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(txd == 1'b1 && busy == 1'b0 && tx_irq == 1'b0, "R1 reset state",
        int'({txd, busy, tx_irq}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R2 idle line high", int'(txd), 1);

    // directed corners
    send(2'b00, 1'b1, 1'b0, 9'h180, 1'b0);  // R12 upper bits set, R5 R6 even
    send(2'b00, 1'b1, 1'b1, 9'h055, 1'b0);  // R6 odd
    send(2'b01, 1'b1, 1'b0, 9'h0FF, 1'b0);  // R5 8-bit even
    send(2'b01, 1'b0, 1'b0, 9'h1A5, 1'b0);  // R4 R12
    send(2'b10, 1'b1, 1'b1, 9'h1C3, 1'b0);  // R7 no parity in 9-bit
    send(2'b11, 1'b1, 1'b0, 9'h101, 1'b0);  // R4 R7 code 11

    // random frames with control and write noise during the frame (R8 R11)
    for (int r = 0; r < 40; r++)
      send(2'($urandom), 1'($urandom), 1'($urandom), 9'($urandom), 1'b1);

    // reset in the middle of a frame (R1)
    @(negedge clk);
    fmt = 2'b01; par_en = 1'b0; wr_data = 9'h000; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1 && busy == 1'b0 && tx_irq == 1'b0, "R1 reset mid frame",
        int'({txd, busy, tx_irq}), 4);
    rst_n = 1'b1;
    send(2'b00, 1'b0, 1'b0, 9'h07F, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule